// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Bank

This block is a register-mapped timer peripheral with four channels. Three of them are reloadable down-counters. Channels 0 and 1 are narrow, 16 bits by default, and channel 2 is wide, 32 bits by default. Each raises its own level interrupt when it counts past zero. The fourth channel is a free-running up-counter, 40 bits by default, that never interrupts. Software reads it as two words.

Two single-cycle tick enables drive the counters: a slow tick and a fast tick. Each down-counter picks one of the two through its control register. The free-running counter always advances on the fast tick. To get a period of N ticks, software writes N−1 to a channel's load register. Software then services the interrupt by writing any value to that channel's clear register.

Top module: `tmr_bank`

## Requirements
- R1: Register map. The down-counters have bases 0x00, 0x20 and 0x80. Within a base, the offsets are 0x0 for load, 0x4 for current value (read-only), 0x8 for control and 0xC for clear (write-only; it reads as zero). `bus_rdata` shows the selected register the cycle after `bus_rd` and holds its value while no read is issued.
- R2: Control register fields. Bit 7 enables counting. Bit 6 selects periodic mode. Bit 3 selects the fast tick (1) or the slow tick (0). A read returns only these three bits, with all other bits zero.
- R3: An enabled down-counter decrements by one on each tick of its selected source. The unselected tick has no effect. A disabled counter holds its value.
- R4: In periodic mode, a tick at value 0 reloads the counter from the load register. The period is therefore load+1 ticks.
- R5: With periodic mode off, a tick at value 0 wraps the counter to all ones at the channel's width.
- R6: `irq[i]` is set by a tick at value 0 and stays high until channel i's clear register is written. When a clear write and an underflow fall in the same cycle, the interrupt stays set.
- R7: A load write sets both the load register and the current value at the same edge. It takes priority over a tick in that cycle.
- R8: Narrow channels keep only the low `NARROW_W` bits of a load write and read back zero above them. The wide channel keeps `WIDE_W` bits.
- R9: The free-running counter increments on each fast tick while bit 8 of register 0x64 is set. Writing 0 to that bit stops the counter and zeroes it. This counter never drives an interrupt.
- R10: A read of 0x60 returns the low `FREE_LO_W` bits of the free-running counter. The same read latches the counter's upper bits. A read of 0x64 returns those latched bits in [7:0] and the enable in bit 8.
- R11: Writes to the value registers (0x04, 0x24, 0x84) and to 0x60 are ignored.
- R12: After reset, every register, counter, interrupt and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_slow | input | 1 | Slow tick enable, one cycle per tick |
| tick_fast | input | 1 | Fast tick enable, one cycle per tick |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 3 | Level interrupts of the three down-counters |

## Verification
The assertions assume that a clear write is decoded only from the exact clear address. They also assume that a write to 0x64 is the only thing, besides a tick, that can change the free-running counter. The bench keeps to these assumptions: it drives every strobe and tick for one whole cycle between falling edges, and it never issues a read in the same cycle as a write. The bench uses a 12-bit free-running counter split at bit 8, so the latched upper bits can be exercised within a short run. It sweeps load values 0 to 3 over all three down-counters, and it computes the expected count and interrupt from the tick number.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned NUM_CH   = 3;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 32;

    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_VALUE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 8'h0C;

    localparam logic [ADDR_W-1:0] FREE_LO_ADDR = 8'h60;
    localparam logic [ADDR_W-1:0] FREE_HI_ADDR = 8'h64;

    localparam int unsigned CTL_EN_BIT   = 7;
    localparam int unsigned CTL_PER_BIT  = 6;
    localparam int unsigned CTL_FAST_BIT = 3;
    localparam int unsigned FREE_EN_BIT  = 8;

    function automatic logic [ADDR_W-1:0] chan_base(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int unsigned W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_slow,
    input  logic                       tick_fast,
    input  logic                       load_we,
    input  logic                       ctrl_we,
    input  logic                       clr_we,
    input  logic [W-1:0]               load_wdata,
    input  logic                       ctrl_en,
    input  logic                       ctrl_per,
    input  logic                       ctrl_fast,
    output logic [tmr_pkg::DATA_W-1:0] val_word,
    output logic [tmr_pkg::DATA_W-1:0] load_word,
    output logic [tmr_pkg::DATA_W-1:0] ctrl_word,
    output logic                       underflow,
    output logic                       irq
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [W-1:0] load;
        logic [W-1:0] val;
        logic         en;
        logic         per;
        logic         fast;
        logic         irq;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     sel_tick;
    logic     uf_d;

    always_comb begin
        st_d     = st_q;
        uf_d     = 1'b0;
        sel_tick = st_q.fast ? tick_fast : tick_slow;
        if (st_q.en && sel_tick) begin
            if (st_q.val == '0) begin
                uf_d     = 1'b1;
                st_d.val = st_q.per ? st_q.load : '1;
            end else begin
                st_d.val = st_q.val - 1'b1;
            end
        end
        if (load_we) begin
            st_d.load = load_wdata;
            st_d.val  = load_wdata;
        end
        if (ctrl_we) begin
            st_d.en   = ctrl_en;
            st_d.per  = ctrl_per;
            st_d.fast = ctrl_fast;
        end
        if (clr_we) st_d.irq = 1'b0;
        if (uf_d)   st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        val_word            = '0;
        val_word[W-1:0]     = st_q.val;
        load_word           = '0;
        load_word[W-1:0]    = st_q.load;
        ctrl_word               = '0;
        ctrl_word[CTL_EN_BIT]   = st_q.en;
        ctrl_word[CTL_PER_BIT]  = st_q.per;
        ctrl_word[CTL_FAST_BIT] = st_q.fast;
    end

    assign underflow = uf_d;
    assign irq       = st_q.irq;
endmodule

// File: rtl/tmr_free.sv
module tmr_free #(
    parameter int unsigned FREE_W    = 40,
    parameter int unsigned FREE_LO_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       en_we,
    input  logic                       en_wdata,
    input  logic                       lo_rd,
    output logic [tmr_pkg::DATA_W-1:0] lo_word,
    output logic [tmr_pkg::DATA_W-1:0] hi_word,
    output logic [FREE_W-1:0]          cnt,
    output logic                       en
);
    import tmr_pkg::*;

    localparam int unsigned HI_W = FREE_W - FREE_LO_W;

    typedef struct packed {
        logic [FREE_W-1:0] cnt;
        logic [HI_W-1:0]   hi;
        logic              en;
    } free_st_t;

    free_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.en && tick) st_d.cnt = st_q.cnt + 1'b1;
        if (en_we) begin
            st_d.en = en_wdata;
            if (!en_wdata) st_d.cnt = '0;
        end
        if (lo_rd) st_d.hi = st_q.cnt[FREE_W-1:FREE_LO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        lo_word              = '0;
        lo_word[FREE_LO_W-1:0] = st_q.cnt[FREE_LO_W-1:0];
        hi_word              = '0;
        hi_word[HI_W-1:0]    = st_q.hi;
        hi_word[FREE_EN_BIT] = st_q.en;
    end

    assign cnt = st_q.cnt;
    assign en  = st_q.en;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
    parameter int unsigned NARROW_W  = 16,
    parameter int unsigned WIDE_W    = 32,
    parameter int unsigned FREE_W    = 40,
    parameter int unsigned FREE_LO_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_slow,
    input  logic        tick_fast,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [2:0]  irq
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_st_t;

    logic [DATA_W-1:0] ch_val  [NUM_CH];
    logic [DATA_W-1:0] ch_load [NUM_CH];
    logic [DATA_W-1:0] ch_ctrl [NUM_CH];
    logic [NUM_CH-1:0] uf;
    logic [DATA_W-1:0] free_lo, free_hi;
    logic [FREE_W-1:0] free_cnt;
    logic              free_en;
    logic [DATA_W-1:0] rd_mux;
    bus_st_t           bus_d, bus_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int unsigned CW = (g == NUM_CH - 1) ? WIDE_W : NARROW_W;
        localparam logic [ADDR_W-1:0] BASE = chan_base(g);
        tmr_chan #(.W(CW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_slow  (tick_slow),
            .tick_fast  (tick_fast),
            .load_we    (bus_wr && bus_addr == BASE + OFS_LOAD),
            .ctrl_we    (bus_wr && bus_addr == BASE + OFS_CTRL),
            .clr_we     (bus_wr && bus_addr == BASE + OFS_CLEAR),
            .load_wdata (bus_wdata[CW-1:0]),
            .ctrl_en    (bus_wdata[CTL_EN_BIT]),
            .ctrl_per   (bus_wdata[CTL_PER_BIT]),
            .ctrl_fast  (bus_wdata[CTL_FAST_BIT]),
            .val_word   (ch_val[g]),
            .load_word  (ch_load[g]),
            .ctrl_word  (ch_ctrl[g]),
            .underflow  (uf[g]),
            .irq        (irq[g])
        );
    end

    tmr_free #(.FREE_W(FREE_W), .FREE_LO_W(FREE_LO_W)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_fast),
        .en_we    (bus_wr && bus_addr == FREE_HI_ADDR),
        .en_wdata (bus_wdata[FREE_EN_BIT]),
        .lo_rd    (bus_rd && bus_addr == FREE_LO_ADDR),
        .lo_word  (free_lo),
        .hi_word  (free_hi),
        .cnt      (free_cnt),
        .en       (free_en)
    );

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == chan_base(i) + OFS_LOAD)  rd_mux = ch_load[i];
            if (bus_addr == chan_base(i) + OFS_VALUE) rd_mux = ch_val[i];
            if (bus_addr == chan_base(i) + OFS_CTRL)  rd_mux = ch_ctrl[i];
        end
        if (bus_addr == FREE_LO_ADDR) rd_mux = free_lo;
        if (bus_addr == FREE_HI_ADDR) rd_mux = free_hi;
        bus_d = bus_q;
        if (bus_rd) bus_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign bus_rdata = bus_q.rdata;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int unsigned FREE_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_fast,
    input logic [7:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [2:0]        irq,
    input logic [2:0]        uf,
    input logic [FREE_W-1:0] free_cnt,
    input logic              free_en
);
    import tmr_pkg::*;

    logic free_wr;
    assign free_wr = bus_wr && bus_addr == FREE_HI_ADDR;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
        logic clr;
        assign clr = bus_wr && bus_addr == chan_base(g) + OFS_CLEAR;

        p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            uf[g] |=> irq[g]);
        p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] && !clr |=> irq[g]);
        p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clr && !uf[g] |=> !irq[g]);
    end

    p_free_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        free_en && tick_fast && !free_wr |=> free_cnt == $past(free_cnt) + 1'b1);
    p_free_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_fast && !free_wr |=> $stable(free_cnt));
    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind tmr_bank tmr_bank_chk #(.FREE_W(FREE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_fast (tick_fast),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .uf        (uf),
    .free_cnt  (free_cnt),
    .free_en   (free_en)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_slow = 1'b0;
    logic        tick_fast = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_bank #(.NARROW_W(16), .WIDE_W(32), .FREE_W(12), .FREE_LO_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] base(input int ch);
        return (ch == 0) ? 8'h00 : (ch == 1) ? 8'h20 : 8'h80;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic tick(input bit fast, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
            @(negedge clk);
            tick_fast = 1'b0; tick_slow = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int exp_v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        check("R12 irq", {29'b0, irq}, 32'h0);
        for (int ch = 0; ch < 3; ch++) begin
            rd(base(ch) + 8'h0, v); check("R12 load", v, 0);
            rd(base(ch) + 8'h4, v); check("R12 value", v, 0);
            rd(base(ch) + 8'h8, v); check("R12 ctrl", v, 0);
        end
        rd(8'h60, v); check("R12 free lo", v, 0);
        rd(8'h64, v); check("R12 free hi", v, 0);

        // R3 R4 R6: periodic sweep, every channel, load 0..3
        for (int ch = 0; ch < 3; ch++) begin
            for (int ld = 0; ld < 4; ld++) begin
                wr(base(ch) + 8'h8, 32'h0);
                wr(base(ch) + 8'hC, 32'h0);
                wr(base(ch) + 8'h0, ld);
                wr(base(ch) + 8'h8, 32'hC8);
                for (int k = 1; k <= 2 * (ld + 1); k++) begin
                    tick(1'b1, 1);
                    exp_v = ld - (k % (ld + 1));
                    check("R6 irq after underflow", {31'b0, irq[ch]}, {31'b0, k >= ld + 1});
                    rd(base(ch) + 8'h4, v);
                    check("R4 periodic count", v, exp_v);
                end
                wr(base(ch) + 8'hC, 32'h5A);
                check("R6 clear", {31'b0, irq[ch]}, 32'h0);
            end
            wr(base(ch) + 8'h8, 32'h0);
        end

        // R5: wrap when periodic mode is off
        wr(8'h00, 1); wr(8'h08, 32'h88);
        tick(1'b1, 2);
        rd(8'h04, v); check("R5 narrow wrap", v, 32'h0000FFFF);
        tick(1'b1, 1);
        rd(8'h04, v); check("R5 narrow wrap-1", v, 32'h0000FFFE);
        check("R6 irq on wrap", {31'b0, irq[0]}, 32'h1);
        wr(8'h08, 0); wr(8'h0C, 0);
        wr(8'h80, 0); wr(8'h88, 32'h88);
        tick(1'b1, 1);
        rd(8'h84, v); check("R5 wide wrap", v, 32'hFFFFFFFF);
        wr(8'h88, 0); wr(8'h8C, 0);

        // R2: clock select and control readback
        wr(8'h28, 32'hFFFFFFFF);
        rd(8'h28, v); check("R2 ctrl readback", v, 32'hC8);
        wr(8'h28, 0);
        wr(8'h20, 7); wr(8'h28, 32'h80);
        tick(1'b1, 3);
        rd(8'h24, v); check("R3 unselected tick ignored", v, 7);
        tick(1'b0, 2);
        rd(8'h24, v); check("R3 slow tick counts", v, 5);

        // R3: disabled channel holds
        wr(8'h28, 32'h48);
        tick(1'b1, 3);
        rd(8'h24, v); check("R3 disabled holds", v, 5);
        wr(8'h28, 0);

        // R6: clear in the same cycle as an underflow
        wr(8'h00, 0); wr(8'h08, 32'hC8);
        tick(1'b1, 1);
        check("R6 set", {31'b0, irq[0]}, 1);
        @(negedge clk);
        tick_fast = 1'b1; bus_addr = 8'h0C; bus_wr = 1'b1;
        @(negedge clk);
        tick_fast = 1'b0; bus_wr = 1'b0;
        check("R6 clear loses to underflow", {31'b0, irq[0]}, 1);
        wr(8'h0C, 0);
        check("R6 clear after", {31'b0, irq[0]}, 0);

        // R7: load while enabled, and load against a tick
        wr(8'h00, 10);
        rd(8'h04, v); check("R7 immediate load", v, 10);
        @(negedge clk);
        tick_fast = 1'b1; bus_addr = 8'h00; bus_wdata = 20; bus_wr = 1'b1;
        @(negedge clk);
        tick_fast = 1'b0; bus_wr = 1'b0;
        rd(8'h04, v); check("R7 load beats tick", v, 20);
        wr(8'h08, 0);

        // R8: widths
        wr(8'h20, 32'h00012345);
        rd(8'h20, v); check("R8 narrow load", v, 32'h2345);
        rd(8'h24, v); check("R8 narrow value", v, 32'h2345);
        wr(8'h80, 32'h12345678);
        rd(8'h84, v); check("R8 wide value", v, 32'h12345678);

        // R11: read-only registers
        wr(8'h24, 32'h99);
        rd(8'h24, v); check("R11 value write ignored", v, 32'h2345);

        // R9 R10: free-running counter (12 bits, split at 8)
        tick(1'b1, 5);
        rd(8'h60, v); check("R9 disabled stays zero", v, 0);
        wr(8'h64, 32'h100);
        rd(8'h64, v); check("R10 enable readback", v, 32'h100);
        tick(1'b1, 300);
        wr(8'h60, 32'h55);
        rd(8'h60, v); check("R10 low word", v, 32'h2C);
        rd(8'h64, v); check("R10 latched high", v, 32'h101);
        tick(1'b1, 212);
        rd(8'h64, v); check("R10 high stays latched", v, 32'h101);
        rd(8'h60, v); check("R11 low write ignored / R10 low", v, 32'h00);
        rd(8'h64, v); check("R10 relatched high", v, 32'h102);
        check("R9 no irq", {29'b0, irq}, 0);
        wr(8'h64, 0);
        tick(1'b1, 2);
        rd(8'h60, v); check("R9 disable zeroes", v, 0);
        rd(8'h64, v); check("R9 disabled high", v, 0);

        finish_run();
    end
endmodule